// File: doc/BRIEF.md
# Packed-Slot Bundle Sequencer

This block feeds a stack-based execution unit from a stream of 64-bit instruction words. Each word is a bundle of sixteen 4-bit slots. The sequencer loads a bundle from a single-port memory, then hands it out in groups:

- four groups of three slots, each passed through a 12-bit combinational classifier;
- two trailing groups of two slots, each passed through a separate 8-bit classifier.

Slot pairs that would cancel each other out are reused as extended operations:

- duplicate (`0xA`) followed by drop (`0xB`) means "literal". The literal's value is the next 64-bit word after the bundle. Each further literal takes the word after that.
- swap followed by swap (`0xC`,`0xC`) means "branch". The branch target comes back from the execution unit.

When a group is a literal, the sequencer reads the immediate word before it offers the group, and attaches that word to it. A word pointer moves past the bundle and past every immediate, so the next bundle is read from the word after the last immediate. When a branch group is accepted with the taken flag set, the rest of the bundle is dropped and the pointer is loaded with the target.

Top module: `slot_bundle_seq`

## Requirements
- R1: While reset is held and right after it, `mem_req` is 1, `mem_addr` equals `RESET_ADDR` (0 by default) and `issue_valid` is 0.
- R2: Once raised, `mem_req` stays high with `mem_addr` unchanged until a cycle in which `mem_rvalid` is 1. That cycle completes the read and delivers `mem_rdata`.
- R3: Each bundle is offered as six issues, in this order:
  - bits 63:52, 51:40, 39:28 and 27:16 as triples, with `issue_tail`=0;
  - bits 15:8, then bits 7:0, as pairs with `issue_tail`=1. A pair is placed in `issue_slots[11:4]`, and `issue_slots[3:0]` is 0.
- R4: A triple is classified in this order:
  - If its first two slots (`issue_slots[11:8]`, `[7:4]`) are A,B, it is literal (kind 1, `issue_xlo`=0). If they are C,C, it is branch (kind 2, `issue_xlo`=0).
  - Otherwise the last two slots (`[7:4]`, `[3:0]`) are tested the same way, giving the same kinds with `issue_xlo`=1.
  - Otherwise the triple is plain (kind 0, `issue_xlo`=0).
- R5: A pair A,B is literal (kind 1). A pair C,C is branch (kind 2). Any other pair is plain (kind 0). `issue_xlo` is always 0 for a pair.
- R6: A literal issue carries, in `issue_imm`, the word read at the pointer. Every non-literal issue carries 0. Each immediate read advances the pointer by one word. A bundle that runs to its end is followed by a fetch at the word after its last immediate.
- R7: While `issue_valid` is 1 and `issue_ready` is 0, the issue stays valid with slots, kind and immediate unchanged.
- R8: An accepted branch issue with `br_taken`=1 drops the rest of the bundle. The next cycle requests `br_target`. With `br_taken`=0, the next group of the bundle follows.
- R9: `br_taken` and `br_target` have no effect on accepted plain or literal issues.
- R10: A `mem_rvalid` pulse while `mem_req` is 0 is ignored. It changes neither the bundle nor the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Word address of the read |
| mem_rvalid | input | 1 | Read data valid; completes the request |
| mem_rdata | input | 64 | Read data |
| issue_valid | output | 1 | A group is offered |
| issue_ready | input | 1 | Execution unit accepts the group |
| issue_slots | output | 12 | Group slots; pairs left-aligned |
| issue_kind | output | 2 | 0 plain, 1 literal, 2 branch |
| issue_xlo | output | 1 | Extended pair sits in the last two slots of a triple |
| issue_tail | output | 1 | Group is a trailing pair |
| issue_imm | output | 64 | Immediate word for literals, else 0 |
| br_taken | input | 1 | Branch resolved taken, sampled at acceptance |
| br_target | input | ADDR_W | Branch target word address |

## Verification
The bench builds the block with the default `ADDR_W`=16 and `RESET_ADDR`=0. This is wide enough to place bundles at scattered addresses (0x40, 0x50), so every redirect and pointer advance shows up as a distinct fetch address. A 128-word memory model answers with a latency of zero to two cycles, which varies per read. It can also inject a read-valid pulse while no request is active. The classification table covers both pair positions, the front-first priority and the near-miss orders. Branches are taken in a triple and in the last pair, and branches not taken let the stream continue.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  localparam int SLOT_W = 4;
  localparam int WORD_W = 64;
  localparam int SLOTS  = WORD_W / SLOT_W;
  localparam int TRI_W  = 3 * SLOT_W;
  localparam int PAIR_W = 2 * SLOT_W;
  localparam int N_TRI  = SLOTS / 3 - 1;
  localparam int N_PAIR = (SLOTS - 3 * N_TRI) / 2;
  localparam int N_GRP  = N_TRI + N_PAIR;
  localparam int IDX_W  = $clog2(N_GRP);

  localparam logic [SLOT_W-1:0] OP_DUP  = 4'hA;
  localparam logic [SLOT_W-1:0] OP_DROP = 4'hB;
  localparam logic [SLOT_W-1:0] OP_SWAP = 4'hC;

  typedef enum logic [1:0] {K_PLAIN = 2'd0, K_LIT = 2'd1, K_BRANCH = 2'd2} kind_e;

  typedef struct packed {
    kind_e kind;
    logic  xlo;
  } gdec_t;

  // 8-bit table: classify one slot pair
  function automatic kind_e pair_kind(input logic [PAIR_W-1:0] p);
    if (p[7:4] == OP_DUP && p[3:0] == OP_DROP) return K_LIT;
    if (p[7:4] == OP_SWAP && p[3:0] == OP_SWAP) return K_BRANCH;
    return K_PLAIN;
  endfunction

  // 12-bit table: front pair has priority over back pair
  function automatic gdec_t triple_dec(input logic [TRI_W-1:0] g);
    kind_e f, b;
    f = pair_kind(g[11:4]);
    b = pair_kind(g[7:0]);
    if (f != K_PLAIN) return '{kind: f, xlo: 1'b0};
    if (b != K_PLAIN) return '{kind: b, xlo: 1'b1};
    return '{kind: K_PLAIN, xlo: 1'b0};
  endfunction

  function automatic int unsigned step_bits(input logic tail);
    return tail ? PAIR_W : TRI_W;
  endfunction
endpackage

// File: rtl/bseq_group_dec.sv
module bseq_group_dec
  import bseq_pkg::*;
(
  input  logic [TRI_W-1:0] win,
  input  logic             tail,
  output kind_e            kind,
  output logic             xlo,
  output logic [TRI_W-1:0] slots
);
  gdec_t tri_res;
  kind_e pair_res;

  always_comb begin
    tri_res  = triple_dec(win);
    pair_res = pair_kind(win[TRI_W-1 -: PAIR_W]);
    if (tail) begin
      kind  = pair_res;
      xlo   = 1'b0;
      slots = {win[TRI_W-1 -: PAIR_W], {(TRI_W-PAIR_W){1'b0}}};
    end else begin
      kind  = tri_res.kind;
      xlo   = tri_res.xlo;
      slots = win;
    end
  end
endmodule

// File: rtl/bseq_bundle.sv
module bseq_bundle
  import bseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] ldata,
  input  logic              step,
  output logic [TRI_W-1:0]  win,
  output logic              tail,
  output logic              last
);
  logic [WORD_W-1:0] bundle_q;
  logic [IDX_W-1:0]  idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bundle_q <= '0;
      idx_q    <= '0;
    end else if (load) begin
      bundle_q <= ldata;
      idx_q    <= '0;
    end else if (step) begin
      bundle_q <= bundle_q << step_bits(tail);
      idx_q    <= idx_q + IDX_W'(1);
    end
  end

  assign win  = bundle_q[WORD_W-1 -: TRI_W];
  assign tail = (idx_q >= IDX_W'(N_TRI));
  assign last = (idx_q == IDX_W'(N_GRP - 1));

  // R3: the group index never runs past the last pair
  a_r3_idx_range: assert property (@(posedge clk) disable iff (rst)
    step |=> (idx_q <= IDX_W'(N_GRP - 1)));
endmodule

// File: rtl/bseq_ptr.sv
module bseq_ptr #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic              redir,
  input  logic [ADDR_W-1:0] tgt,
  output logic [ADDR_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= RESET_ADDR;
    else if (redir) q <= tgt;
    else if (adv)   q <= q + ADDR_W'(1);
  end

  // R6: every consumed word moves the pointer by exactly one
  a_r6_ptr_step: assert property (@(posedge clk) disable iff (rst)
    (adv && !redir) |=> (q == $past(q) + ADDR_W'(1)));
endmodule

// File: rtl/slot_bundle_seq.sv
module slot_bundle_seq
  import bseq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [63:0]       mem_rdata,
  output logic              issue_valid,
  input  logic              issue_ready,
  output logic [11:0]       issue_slots,
  output logic [1:0]        issue_kind,
  output logic              issue_xlo,
  output logic              issue_tail,
  output logic [63:0]       issue_imm,
  input  logic              br_taken,
  input  logic [ADDR_W-1:0] br_target
);
  typedef enum logic {S_FETCH, S_ISSUE} state_e;

  state_e            state_q;
  logic              imm_held_q;
  logic [WORD_W-1:0] imm_q;

  logic [TRI_W-1:0]  win;
  logic              tail, last;
  kind_e             kind;
  logic              xlo;
  logic [TRI_W-1:0]  slots;

  // named internal events
  logic fetch_done, imm_need, imm_done, accept, redirect, is_lit;

  assign is_lit      = (kind == K_LIT);
  assign fetch_done  = (state_q == S_FETCH) && mem_rvalid;
  assign imm_need    = (state_q == S_ISSUE) && is_lit && !imm_held_q;
  assign imm_done    = imm_need && mem_rvalid;
  assign issue_valid = (state_q == S_ISSUE) && !(is_lit && !imm_held_q);
  assign accept      = issue_valid && issue_ready;
  assign redirect    = accept && (kind == K_BRANCH) && br_taken;
  assign mem_req     = (state_q == S_FETCH) || imm_need;

  bseq_bundle u_bundle (
    .clk   (clk),
    .rst   (rst),
    .load  (fetch_done),
    .ldata (mem_rdata),
    .step  (accept && !last),
    .win   (win),
    .tail  (tail),
    .last  (last)
  );

  bseq_group_dec u_dec (
    .win   (win),
    .tail  (tail),
    .kind  (kind),
    .xlo   (xlo),
    .slots (slots)
  );

  bseq_ptr #(.ADDR_W(ADDR_W), .RESET_ADDR(RESET_ADDR)) u_ptr (
    .clk   (clk),
    .rst   (rst),
    .adv   (fetch_done || imm_done),
    .redir (redirect),
    .tgt   (br_target),
    .q     (mem_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= S_FETCH;
      imm_held_q <= 1'b0;
      imm_q      <= '0;
    end else begin
      if (fetch_done) state_q <= S_ISSUE;
      else if (accept && (redirect || last)) state_q <= S_FETCH;
      if (imm_done) begin
        imm_q      <= mem_rdata;
        imm_held_q <= 1'b1;
      end else if (accept) begin
        imm_held_q <= 1'b0;
      end
    end
  end

  assign issue_slots = slots;
  assign issue_kind  = kind;
  assign issue_xlo   = xlo;
  assign issue_tail  = tail;
  assign issue_imm   = is_lit ? imm_q : '0;

  // R2: a pending read keeps its request and address
  a_r2_req_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

  // R7: an offered group waits unchanged for the consumer
  a_r7_issue_hold: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && !issue_ready) |=>
      (issue_valid && $stable(issue_slots) && $stable(issue_kind) && $stable(issue_imm)));

  // R8: a taken branch requests its target next
  a_r8_redirect: assert property (@(posedge clk) disable iff (rst)
    redirect |=> (mem_req && mem_addr == $past(br_target)));

  // R6: an immediate read turns straight into a literal issue
  a_r6_imm_issue: assert property (@(posedge clk) disable iff (rst)
    imm_done |=> (issue_valid && issue_kind == K_LIT));
endmodule

// File: tb/slot_bundle_seq_test.sv
module slot_bundle_seq_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [63:0] mem_rdata = '0;
  logic        issue_valid;
  logic        issue_ready = 1'b0;
  logic [11:0] issue_slots;
  logic [1:0]  issue_kind;
  logic        issue_xlo;
  logic        issue_tail;
  logic [63:0] issue_imm;
  logic        br_taken = 1'b0;
  logic [15:0] br_target = '0;

  int nchk = 0;
  int nfail = 0;

  always #5 clk = ~clk;

  slot_bundle_seq uut (
    .clk(clk), .rst(rst),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .issue_valid(issue_valid), .issue_ready(issue_ready),
    .issue_slots(issue_slots), .issue_kind(issue_kind),
    .issue_xlo(issue_xlo), .issue_tail(issue_tail),
    .issue_imm(issue_imm),
    .br_taken(br_taken), .br_target(br_target)
  );

  // memory model with varying latency and an optional stray valid pulse
  logic [63:0] mem [128];
  logic [15:0] log_addr [32];
  int  nlog = 0;
  int  wait_cnt = 0;
  logic spur = 1'b0;

  initial begin
    forever begin
      @(negedge clk);
      mem_rvalid = 1'b0;
      if (rst) begin
        wait_cnt = 0;
      end else if (!mem_req && spur) begin
        mem_rvalid = 1'b1;
        mem_rdata  = '1;
        spur       = 1'b0;
      end else if (mem_req) begin
        if (wait_cnt >= nlog % 3) begin
          mem_rvalid = 1'b1;
          mem_rdata  = mem[mem_addr[6:0]];
          if (nlog < 32) log_addr[nlog] = mem_addr;
          nlog++;
          wait_cnt = 0;
        end else begin
          wait_cnt++;
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [79:0] act, input logic [79:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // wait for an issue, compare all fields, then accept it
  task automatic take(input logic [1:0] ek, input logic ex, input logic [11:0] es,
                      input logic et, input logic [63:0] ei, input logic bt,
                      input logic [15:0] bg, input string tag);
    logic [79:0] act, exp;
    while (!issue_valid) @(negedge clk);
    act = {1'b0, issue_kind, issue_xlo, issue_slots, issue_tail, issue_imm};
    exp = {1'b0, ek, ex, es, et, ei};
    check(act == exp, tag, act, exp);
    issue_ready = 1'b1;
    br_taken    = bt;
    br_target   = bg;
    @(negedge clk);
    issue_ready = 1'b0;
    br_taken    = 1'b0;
  endtask

  // classification vectors: {group, kind, xlo}
  localparam logic [14:0] TBL [12] = '{
    {12'h123, 2'd0, 1'b0},
    {12'hAB5, 2'd1, 1'b0},
    {12'h7AB, 2'd1, 1'b1},
    {12'hCC4, 2'd2, 1'b0},
    {12'h2CC, 2'd2, 1'b1},
    {12'hABB, 2'd1, 1'b0},
    {12'hCCC, 2'd2, 1'b0},
    {12'hBA1, 2'd0, 1'b0},
    {12'hACC, 2'd2, 1'b1},
    {12'hCAB, 2'd1, 1'b1},
    {12'h000, 2'd0, 1'b0},
    {12'hFFF, 2'd0, 1'b0}
  };

  function automatic logic [63:0] immv(input int i);
    return 64'hC0DE_0000_0000_0000 | 64'(i);
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int a;
    int exp_log [16];
    int nexp;
    for (int i = 0; i < 128; i++) mem[i] = '0;
    a = 0;
    nexp = 0;
    for (int b = 0; b < 3; b++) begin
      mem[a] = {TBL[4*b][14:3], TBL[4*b+1][14:3], TBL[4*b+2][14:3], TBL[4*b+3][14:3], 16'h1234};
      exp_log[nexp++] = a;
      a++;
      for (int j = 0; j < 4; j++)
        if (TBL[4*b+j][2:1] == 2'd1) begin
          mem[a] = immv(4*b+j);
          exp_log[nexp++] = a;
          a++;
        end
    end
    mem[a] = {12'hCC1, 12'h0, 12'h0, 12'h0, 16'h1234};
    exp_log[nexp++] = a;
    mem[7'h40] = {12'h111, 12'h222, 12'h333, 12'h444, 8'hAB, 8'hCC};
    mem[7'h41] = 64'hFEED_0000_0000_0041;
    mem[7'h50] = {12'h555, 12'h666, 12'h777, 12'h888, 16'h9876};
    exp_log[nexp++] = 'h40;
    exp_log[nexp++] = 'h41;
    exp_log[nexp++] = 'h50;

    // R1: reset state
    repeat (3) @(negedge clk);
    check(mem_req == 1'b1 && mem_addr == 16'h0 && issue_valid == 1'b0, "R1 reset",
          {62'b0, mem_req, mem_addr, issue_valid}, {62'b0, 1'b1, 16'h0, 1'b0});
    rst = 1'b0;

    // table walk: R3 order, R4 classes, R6 immediates, R8 not taken, R9 ignored
    for (int b = 0; b < 3; b++) begin
      for (int j = 0; j < 4; j++) begin
        logic [14:0] e;
        e = TBL[4*b+j];
        take(e[2:1], e[0], e[14:3], 1'b0, (e[2:1] == 2'd1) ? immv(4*b+j) : 64'h0,
             (e[2:1] != 2'd2), 16'h003F, "R4 R6 R9 triple");
      end
      take(2'd0, 1'b0, 12'h120, 1'b1, 64'h0, 1'b1, 16'h003F, "R3 R5 pair0");
      take(2'd0, 1'b0, 12'h340, 1'b1, 64'h0, 1'b1, 16'h003F, "R3 R5 pair1");
    end

    // R8: taken branch in the first triple drops the rest
    take(2'd2, 1'b0, 12'hCC1, 1'b0, 64'h0, 1'b1, 16'h0040, "R8 taken triple");

    // R7: stall on the first group at 0x40
    while (!issue_valid) @(negedge clk);
    repeat (3) @(negedge clk);
    check(issue_valid && issue_slots == 12'h111, "R7 hold",
          {67'b0, issue_valid, issue_slots}, {67'b0, 1'b1, 12'h111});
    take(2'd0, 1'b0, 12'h111, 1'b0, 64'h0, 1'b0, 16'h0, "R8 R7 target bundle");
    spur = 1'b1;
    take(2'd0, 1'b0, 12'h222, 1'b0, 64'h0, 1'b0, 16'h0, "R10 stray valid");
    take(2'd0, 1'b0, 12'h333, 1'b0, 64'h0, 1'b0, 16'h0, "R3 triple");
    take(2'd0, 1'b0, 12'h444, 1'b0, 64'h0, 1'b0, 16'h0, "R3 triple");
    take(2'd1, 1'b0, 12'hAB0, 1'b1, 64'hFEED_0000_0000_0041, 1'b1, 16'h003F, "R5 R6 R9 pair literal");
    take(2'd2, 1'b0, 12'hCC0, 1'b1, 64'h0, 1'b1, 16'h0050, "R5 R8 pair branch");

    // bundle at 0x50 runs to its end
    take(2'd0, 1'b0, 12'h555, 1'b0, 64'h0, 1'b0, 16'h0, "R3 g0");
    take(2'd0, 1'b0, 12'h666, 1'b0, 64'h0, 1'b0, 16'h0, "R3 g1");
    take(2'd0, 1'b0, 12'h777, 1'b0, 64'h0, 1'b0, 16'h0, "R3 g2");
    take(2'd0, 1'b0, 12'h888, 1'b0, 64'h0, 1'b0, 16'h0, "R3 g3");
    take(2'd0, 1'b0, 12'h980, 1'b1, 64'h0, 1'b0, 16'h0, "R3 g4");
    take(2'd0, 1'b0, 12'h760, 1'b1, 64'h0, 1'b0, 16'h0, "R3 g5");
    check(mem_req && mem_addr == 16'h0051 && !issue_valid, "R6 next bundle",
          {63'b0, mem_req, mem_addr}, {63'b0, 1'b1, 16'h0051});

    // R2 R6 R8 R10: the sequence of addresses actually read
    check(nlog >= nexp, "R2 read count", 80'(nlog), 80'(nexp));
    for (int k = 0; k < nexp; k++)
      check(int'(log_addr[k]) == exp_log[k], "R2 R6 R8 R10 fetch address",
            80'(log_addr[k]), 80'(exp_log[k]));

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule